// File: doc/BRIEF.md
# Reloadable Constant-Coefficient Table Multiplier

This block multiplies an 8-bit unsigned operand by an 8-bit constant that is held inside the block. It has no multiplier array. A small register table holds the sixteen products of the constant with every 4-bit value. The operand is cut into a low nibble and a high nibble. Each nibble reads one table entry, and the two partial products are weighted and added to form the 16-bit product.

The constant changes only now and then. When a new one arrives, an on-chip filler rewrites the table in sixteen cycles. It keeps a running sum, so each entry equals the previous entry plus the constant, and it needs no multiplier. During the rewrite the operand port stalls, so no result is ever formed from a half-written table.

Operands enter through a valid/ready handshake, one per cycle. Each result leaves two cycles after its operand with a one-cycle valid strobe. After reset the table is all zeros, so the block behaves as a multiply by 0 until the first constant load.

Top module: `kmul_nibble_lut`

## Requirements
- R1: After reset `res_valid` and `k_busy` are low, `op_ready` is high, and every accepted operand yields a product of 0 until the first load completes.
- R2: For each accepted operand X, `res_data` equals X times the current constant K as a 16-bit unsigned value. The low nibble (bits 3:0) selects entry X[3:0] and the high nibble (bits 7:4) selects entry X[7:4]. The second entry is weighted by 16.
- R3: An operand accepted at a clock edge (`op_valid` and `op_ready` both high) produces `res_valid` high for exactly one cycle, visible after the second following edge. Operands can be accepted on consecutive cycles, and `res_valid` is low when no result is due.
- R4: A `k_load` pulse sampled while `k_busy` is low captures `k_value` and starts a rebuild. `k_busy` rises after that edge and stays high for exactly 16 cycles.
- R5: While `k_busy` is high, `op_ready` is low and no operand is accepted. An operand held valid through a rebuild is taken after `k_busy` falls and uses the new constant.
- R6: A `k_load` sampled while `k_busy` is high is ignored. The constant being loaded is not changed and the rebuild is not lengthened.
- R7: An operand accepted at the same edge that starts a rebuild is multiplied by the previous constant. The first operand accepted after the rebuild uses the new constant.
- R8: The rebuild writes entries in ascending index order 0 to 15. Entry 0 is 0 and each later entry is the previous one plus the constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operand offered |
| op_data | input | 8 | Unsigned operand |
| op_ready | output | 1 | Operand can be taken (low during a rebuild) |
| res_valid | output | 1 | Product valid strobe |
| res_data | output | 16 | Unsigned product |
| k_load | input | 1 | Request to load a new constant |
| k_value | input | 8 | New constant value |
| k_busy | output | 1 | Table rebuild in progress |

## Verification
The two functions that can land on one edge are operand acceptance and the start of a table rebuild. While `k_busy` is low, `op_ready` is still high when a `k_load` arrives. The bench raises `op_valid` and `k_load` at the same falling edge and pushes the old-constant product into the scoreboard for that operand. It then expects the next held operand to wait exactly sixteen busy cycles and to come out multiplied by the new constant. A second load raised in the middle of a rebuild must leave both the busy length and the loaded constant unchanged.

// File: rtl/kmul_pkg.sv
package kmul_pkg;

  // width of one partial product: slice value times constant
  function automatic int pp_width(input int slice_w, input int k_w);
    return slice_w + k_w;
  endfunction

  // number of table entries addressed by one slice
  function automatic int entry_count(input int slice_w);
    return 1 << slice_w;
  endfunction

endpackage

// File: rtl/kmul_table_loader.sv
module kmul_table_loader #(
  parameter int K_W     = 8,
  parameter int PP_W    = 12,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [K_W-1:0]   load_k,
  output logic             busy,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [PP_W-1:0]  wr_data
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PP_W-1:0]  acc_q, acc_d;
  logic [K_W-1:0]   k_q, k_d;
  logic             start;

  assign start = load_req && !busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    k_d    = k_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      acc_d  = '0;
      k_d    = load_k;
    end else if (busy_q) begin
      acc_d = acc_q + {{(PP_W-K_W){1'b0}}, k_q};
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      k_q    <= '0;
    end else begin
      busy_q <= busy_d;
      if (start || busy_q) begin
        idx_q <= idx_d;
        acc_q <= acc_d;
      end
      if (start) k_q <= k_d;
    end
  end

  assign busy    = busy_q;
  assign wr_en   = busy_q;
  assign wr_idx  = idx_q;
  assign wr_data = acc_q;

  AST_FIRST_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0) |-> (wr_data == '0)); // R8

  AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_idx == IDX_W'($past(wr_idx) + 1'b1))); // R8

  AST_FILL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(wr_idx) == LAST_IDX)); // R4

  AST_CONST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(k_q)); // R6

endmodule

// File: rtl/kmul_prod_table.sv
module kmul_prod_table #(
  parameter int PP_W    = 12,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int NRD     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [PP_W-1:0]            wr_data,
  input  logic                       rd_en,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][PP_W-1:0]   rd_data
);

  logic [PP_W-1:0] mem_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (hit) begin
        mem_q[e] <= wr_data;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_read
    assign rd_data[r] = mem_q[rd_idx[r]];
  end

  AST_NO_READ_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_en); // R5

endmodule

// File: rtl/kmul_slice_sum.sv
module kmul_slice_sum #(
  parameter int NSLICE  = 2,
  parameter int SLICE_W = 4,
  parameter int PP_W    = 12,
  parameter int RES_W   = 16
) (
  input  logic [NSLICE-1:0][PP_W-1:0] pp,
  output logic [RES_W-1:0]            sum
);

  always_comb begin
    sum = '0;
    for (int s = 0; s < NSLICE; s++) begin
      sum = sum + (RES_W'(pp[s]) << (s * SLICE_W));
    end
  end

endmodule

// File: rtl/kmul_nibble_lut.sv
module kmul_nibble_lut #(
  parameter int OP_W    = 8,
  parameter int K_W     = 8,
  parameter int SLICE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_data,
  output logic             op_ready,
  output logic             res_valid,
  output logic [OP_W+K_W-1:0] res_data,
  input  logic             k_load,
  input  logic [K_W-1:0]   k_value,
  output logic             k_busy
);

  localparam int NSLICE  = OP_W / SLICE_W;
  localparam int ENTRIES = kmul_pkg::entry_count(SLICE_W);
  localparam int IDX_W   = SLICE_W;
  localparam int PP_W    = kmul_pkg::pp_width(SLICE_W, K_W);
  localparam int RES_W   = OP_W + K_W;

  logic                          busy;
  logic                          wr_en;
  logic [IDX_W-1:0]              wr_idx;
  logic [PP_W-1:0]               wr_data;
  logic                          accept;
  logic [NSLICE-1:0][IDX_W-1:0]  rd_idx;
  logic [NSLICE-1:0][PP_W-1:0]   rd_data;
  logic [RES_W-1:0]              sum;

  logic                          s1_valid_q, s1_valid_d;
  logic [NSLICE-1:0][PP_W-1:0]   s1_pp_q, s1_pp_d;
  logic                          s2_valid_q, s2_valid_d;
  logic [RES_W-1:0]              s2_res_q, s2_res_d;

  kmul_table_loader #(
    .K_W(K_W), .PP_W(PP_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_loader (
    .clk(clk), .rst_n(rst_n),
    .load_req(k_load), .load_k(k_value),
    .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign rd_idx[s] = op_data[s*SLICE_W +: SLICE_W];
  end

  kmul_prod_table #(
    .PP_W(PP_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .NRD(NSLICE)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(accept), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  kmul_slice_sum #(
    .NSLICE(NSLICE), .SLICE_W(SLICE_W), .PP_W(PP_W), .RES_W(RES_W)
  ) u_sum (
    .pp(s1_pp_q), .sum(sum)
  );

  always_comb begin
    s1_valid_d = accept;
    s1_pp_d    = accept ? rd_data : s1_pp_q;
    s2_valid_d = s1_valid_q;
    s2_res_d   = s1_valid_q ? sum : s2_res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_pp_q    <= '0;
      s2_valid_q <= 1'b0;
      s2_res_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
      if (accept)     s1_pp_q  <= s1_pp_d;
      if (s1_valid_q) s2_res_q <= s2_res_d;
    end
  end

  assign res_valid = s2_valid_q;
  assign res_data  = s2_res_q;
  assign k_busy    = busy;

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(accept, 2)); // R3

endmodule

// File: tb/kmul_nibble_lut_test.sv
`timescale 1ns/1ps
module kmul_nibble_lut_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  op_data;
  logic        op_ready;
  logic        res_valid;
  logic [15:0] res_data;
  logic        k_load;
  logic [7:0]  k_value;
  logic        k_busy;

  always #2 clk = ~clk;

  kmul_nibble_lut uut (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_data(op_data), .op_ready(op_ready),
    .res_valid(res_valid), .res_data(res_data),
    .k_load(k_load), .k_value(k_value), .k_busy(k_busy)
  );

  typedef struct {
    logic [15:0] val;
    int          due;
    logic [7:0]  op;
  } exp_t;

  exp_t  sb[$];
  exp_t  got;
  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  logic [7:0] model_k;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: pop and compare each result
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 result with nothing due", 32'(res_data), 0);
      end else begin
        got = sb.pop_front();
        check(res_data == got.val, "R2 product", 32'(res_data), 32'(got.val));
        check(cyc == got.due, "R3 latency", cyc, got.due);
      end
    end
  end

  task automatic push_expect(input logic [7:0] v, input logic [7:0] k);
    exp_t e;
    e.val = 16'(v) * 16'(k);
    e.due = cyc + 2;
    e.op  = v;
    sb.push_back(e);
  endtask

  // offer one operand, hold it until taken (R5 stall)
  task automatic drive_op(input logic [7:0] v);
    @(negedge clk);
    k_load   = 1'b0;
    op_valid = 1'b1;
    op_data  = v;
    while (!op_ready) begin
      check(k_busy == 1'b1, "R5 ready low only while busy", 32'(k_busy), 1);
      @(negedge clk);
    end
    push_expect(v, model_k);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
      k_load   = 1'b0;
    end
  endtask

  // count busy cycles after a started load
  task automatic count_busy(output int n);
    n = 0;
    while (k_busy && n < 100) begin
      check(op_ready == 1'b0, "R5 ready low during rebuild", 32'(op_ready), 0);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic load_const(input logic [7:0] k);
    int n;
    @(negedge clk);
    op_valid = 1'b0;
    check(k_busy == 1'b0, "R4 idle before load", 32'(k_busy), 0);
    k_load  = 1'b1;
    k_value = k;
    model_k = k;
    @(negedge clk);
    k_load = 1'b0;
    count_busy(n);
    check(n == 16, "R4 rebuild length", n, 16);
  endtask

  task automatic sweep(input bit gaps);
    for (int v = 0; v < 256; v++) begin
      drive_op(8'(v));
      if (gaps && (v % 5 == 0)) idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R3 all results delivered", sb.size(), 0);
  endtask

  initial begin
    int n;
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_data  = '0;
    k_load   = 1'b0;
    k_value  = '0;
    model_k  = 8'd0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1 res_valid in reset", 32'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0, "R1 res_valid after reset", 32'(res_valid), 0);
    check(k_busy == 1'b0, "R1 busy after reset", 32'(k_busy), 0);
    check(op_ready == 1'b1, "R1 ready after reset", 32'(op_ready), 1);

    // R1: zero table before any load
    sweep(1'b0);

    // R2 R8: full sweeps over several constants
    load_const(8'd1);   sweep(1'b0);
    load_const(8'd128); sweep(1'b1);
    load_const(8'd255); sweep(1'b0);
    load_const(8'd0);   sweep(1'b1);
    load_const(8'hA7);  sweep(1'b0);

    // R7: operand and load on the same edge
    @(negedge clk);
    op_valid = 1'b1;
    op_data  = 8'hEE;
    k_load   = 1'b1;
    k_value  = 8'h33;
    check(op_ready == 1'b1, "R7 ready on load edge", 32'(op_ready), 1);
    push_expect(8'hEE, model_k);
    model_k = 8'h33;
    @(negedge clk);
    k_load = 1'b0;
    check(k_busy == 1'b1, "R4 busy after load edge", 32'(k_busy), 1);
    // R5: operand held through the rebuild, then takes new constant
    op_data = 8'hEE;
    drive_op(8'hEE);
    drive_op(8'h0F);
    idle(4);
    check(sb.size() == 0, "R7 drained", sb.size(), 0);

    // R6: load request during a rebuild is ignored
    @(negedge clk);
    op_valid = 1'b0;
    k_load   = 1'b1;
    k_value  = 8'h21;
    model_k  = 8'h21;
    @(negedge clk);
    k_load = 1'b0;
    repeat (3) @(negedge clk);
    k_load  = 1'b1;
    k_value = 8'h99;
    @(negedge clk);
    k_load = 1'b0;
    count_busy(n);
    check(n == 12, "R6 rebuild not lengthened", n, 12);
    sweep(1'b1);

    load_const(8'h5C); sweep(1'b0);
    finish_run();
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

endmodule